// File: doc/BRIEF.md
# Supervisory Reset Delay Sequencer

This block turns digitized supervisor flags into clean, stretched, active-low reset outputs. Its inputs are a "supply above threshold" flag, a "sense input above reference" flag, an active-low manual reset request and a one-cycle watchdog-expiry pulse. The three level inputs are asynchronous, so each passes through a synchronizer chain before the logic sees it. The outputs are released only after a programmable number of ticks of a slow enable strobe has passed with no reset cause present.

The `DUAL_MODE` parameter picks between two structures. In combined mode, every cause feeds one delay timer, and both reset outputs carry the same value. In dual mode, output A follows the supply flag, the manual request and the watchdog, and output B follows the sense flag and the manual request. Each output then has its own delay timer. The `OD_STYLE` parameter sets how the pad drive-enable outputs behave. With open-drain style, a drive enable is high only while its reset is asserted. With push-pull style, the drive enable is always high. A 2-bit status output reports the cause that most recently asserted reset.

Top module: `supv_reset_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, both reset outputs are low after that edge and `last_cause` is 0 (supply). After `rst_n` is released, the synchronized flags start from "supply low, sense low, manual not pressed".
- R2: A low level on `supply_ok_in` drives `rst_a_n` low on the edge that is `SYNC_STAGES`+1 edges after the change.
- R3: Once every level cause of an output has cleared, the output is released on the edge that carries the `DELAY_TICKS`-th tick. The ticks are counted from the first edge at which the synchronized causes are clear. With a tick on every cycle, this is `SYNC_STAGES`+`DELAY_TICKS` edges after the input change.
- R4: If a cause returns during or after the delay, the output is asserted again, and the full delay restarts when that cause clears.
- R5: A low `man_rst_in_n` asserts both outputs in either mode. The outputs stay low while the request is held and are released as in R3.
- R6: In combined mode, a low `sense_ok_in` also asserts the single reset, and `rst_b_n` always equals `rst_a_n`.
- R7: In dual mode, `rst_a_n` does not respond to `sense_ok_in`, and `rst_b_n` responds neither to `supply_ok_in` nor to `wdog_expire`.
- R8: A one-cycle `wdog_expire` pulse drives `rst_a_n` low from the next edge for exactly `DELAY_TICKS` ticks. A further pulse during that time restarts the count.
- R9: A clock edge without `tick_en` never releases a reset, and an asserted output waits indefinitely for ticks.
- R10: `last_cause` encodes supply=0, sense=1, manual=2 and watchdog=3. It changes only when a cause newly appears. When several causes appear on the same edge, the priority is supply, then manual, then sense, then watchdog.
- R11: With `OD_STYLE`=1, each drive enable equals the inverse of its reset output. With `OD_STYLE`=0, each drive enable is constantly 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| tick_en | input | 1 | Slow enable strobe that paces the delay |
| supply_ok_in | input | 1 | Asynchronous flag: supply above threshold |
| sense_ok_in | input | 1 | Asynchronous flag: sense input above reference |
| man_rst_in_n | input | 1 | Asynchronous manual reset request, active low |
| wdog_expire | input | 1 | Synchronous one-cycle watchdog expiry pulse |
| rst_a_n | output | 1 | Reset output A (single reset in combined mode), active low |
| rst_b_n | output | 1 | Reset output B (sense channel in dual mode), active low |
| drv_a_en | output | 1 | Pad drive enable for output A |
| drv_b_en | output | 1 | Pad drive enable for output B |
| last_cause | output | 2 | Cause that most recently asserted reset |

## Verification
The level inputs reach an output `SYNC_STAGES`+1 edges after they change. A watchdog pulse reaches `rst_a_n` one edge later. When ticks arrive every cycle, a release comes `SYNC_STAGES`+`DELAY_TICKS` edges after a level input clears, and `DELAY_TICKS`+1 edges after the last watchdog pulse. The bench drives stimulus on the falling edge and then counts falling-edge samples until the output changes. It compares that count with the figures above, so each check lands exactly on the edge where the result is due. Boundary sweeps drop the supply after every possible number of cycles into the delay, and retrigger the watchdog at every offset within its window.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    CAUSE_SUPPLY = 2'd0,
    CAUSE_SENSE  = 2'd1,
    CAUSE_MANUAL = 2'd2,
    CAUSE_WDOG   = 2'd3
  } cause_e;

  // True when the tick about to be counted is the last one of the delay.
  function automatic logic delay_done(input int unsigned elapsed,
                                      input int unsigned ticks);
    return (elapsed + 1) >= ticks;
  endfunction

  // Fixed priority among causes that start on the same edge.
  function automatic cause_e pick_cause(input logic sup, input logic sns,
                                        input logic man, input logic wd);
    if (sup)      return CAUSE_SUPPLY;
    else if (man) return CAUSE_MANUAL;
    else if (sns) return CAUSE_SENSE;
    else          return CAUSE_WDOG;
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RESET_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/supv_delay_chan.sv
module supv_delay_chan
  import supv_pkg::*;
#(
  parameter int DELAY_TICKS = 130,
  parameter bit OD_STYLE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hold,
  input  logic kick,
  output logic rst_out_n,
  output logic drv_en
);
  localparam int CW = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;

  logic          asserted;
  logic [CW-1:0] elapsed;
  logic          last_tick;

  assign last_tick = delay_done(32'(elapsed), DELAY_TICKS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asserted <= 1'b1;
      elapsed  <= '0;
    end else if (hold || kick) begin
      asserted <= 1'b1;
      elapsed  <= '0;
    end else if (asserted && tick) begin
      if (last_tick) begin
        asserted <= 1'b0;
        elapsed  <= '0;
      end else begin
        elapsed <= elapsed + 1'b1;
      end
    end
  end

  assign rst_out_n = ~asserted;

  generate
    if (OD_STYLE) begin : g_od
      assign drv_en = asserted;
    end else begin : g_pp
      assign drv_en = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/supv_cause.sv
module supv_cause
  import supv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_fail,
  input  logic       sense_fail,
  input  logic       man_on,
  input  logic       wdog,
  output logic       any_start,
  output logic [1:0] cause
);
  logic   sup_q, sns_q, man_q;
  logic   sup_st, sns_st, man_st;
  cause_e cause_q;

  assign sup_st    = supply_fail & ~sup_q;
  assign sns_st    = sense_fail & ~sns_q;
  assign man_st    = man_on & ~man_q;
  assign any_start = sup_st | sns_st | man_st | wdog;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sup_q   <= 1'b1;
      sns_q   <= 1'b1;
      man_q   <= 1'b0;
      cause_q <= CAUSE_SUPPLY;
    end else begin
      sup_q <= supply_fail;
      sns_q <= sense_fail;
      man_q <= man_on;
      if (any_start) cause_q <= pick_cause(sup_st, sns_st, man_st, wdog);
    end
  end

  assign cause = cause_q;
endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq #(
  parameter bit DUAL_MODE = 1'b0,
  parameter int DELAY_TICKS = 130,
  parameter int SYNC_STAGES = 2,
  parameter bit OD_STYLE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       supply_ok_in,
  input  logic       sense_ok_in,
  input  logic       man_rst_in_n,
  input  logic       wdog_expire,
  output logic       rst_a_n,
  output logic       rst_b_n,
  output logic       drv_a_en,
  output logic       drv_b_en,
  output logic [1:0] last_cause
);
  // Bit order of the synchronized bundle: {manual_n, sense_ok, supply_ok}
  localparam logic [2:0] SYNC_INIT = 3'b100;

  logic [2:0] flags_s;
  logic       supply_fail, sense_fail, man_on;
  logic       hold_a, hold_b, kick_a;
  logic       cause_start;

  supv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(SYNC_INIT)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({man_rst_in_n, sense_ok_in, supply_ok_in}),
    .dout (flags_s)
  );

  assign supply_fail = ~flags_s[0];
  assign sense_fail  = ~flags_s[1];
  assign man_on      = ~flags_s[2];
  assign kick_a      = wdog_expire;

  generate
    if (DUAL_MODE) begin : g_dual
      assign hold_a = supply_fail | man_on;
      assign hold_b = sense_fail | man_on;

      supv_delay_chan #(.DELAY_TICKS(DELAY_TICKS), .OD_STYLE(OD_STYLE)) chan_a_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .hold(hold_a), .kick(kick_a),
        .rst_out_n(rst_a_n), .drv_en(drv_a_en)
      );
      supv_delay_chan #(.DELAY_TICKS(DELAY_TICKS), .OD_STYLE(OD_STYLE)) chan_b_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .hold(hold_b), .kick(1'b0),
        .rst_out_n(rst_b_n), .drv_en(drv_b_en)
      );
    end else begin : g_comb
      assign hold_a = supply_fail | sense_fail | man_on;
      assign hold_b = hold_a;

      supv_delay_chan #(.DELAY_TICKS(DELAY_TICKS), .OD_STYLE(OD_STYLE)) chan_a_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .hold(hold_a), .kick(kick_a),
        .rst_out_n(rst_a_n), .drv_en(drv_a_en)
      );
      assign rst_b_n  = rst_a_n;
      assign drv_b_en = drv_a_en;
    end
  endgenerate

  supv_cause cause_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_fail(supply_fail),
    .sense_fail (sense_fail),
    .man_on     (man_on),
    .wdog       (wdog_expire),
    .any_start  (cause_start),
    .cause      (last_cause)
  );
endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic       hold_a,
  input logic       hold_b,
  input logic       kick_a,
  input logic       rst_a_n,
  input logic       rst_b_n,
  input logic       cause_start,
  input logic [1:0] last_cause
);
  AST_HOLD_A_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_a |=> !rst_a_n); // R2
  AST_HOLD_B_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_b |=> !rst_b_n); // R7
  AST_KICK_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    kick_a |=> !rst_a_n); // R8
  AST_RELEASE_A_PACED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_a_n) |-> ($past(tick_en) && !$past(hold_a))); // R9
  AST_RELEASE_B_PACED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_b_n) |-> ($past(tick_en) && !$past(hold_b))); // R3
  AST_CAUSE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_start |=> $stable(last_cause)); // R10
endmodule

bind supv_reset_seq supv_reset_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .hold_a     (hold_a),
  .hold_b     (hold_b),
  .kick_a     (kick_a),
  .rst_a_n    (rst_a_n),
  .rst_b_n    (rst_b_n),
  .cause_start(cause_start),
  .last_cause (last_cause)
);

// File: tb/supv_reset_seq_tb.sv
module supv_reset_seq_tb_top;
  localparam int DLY  = 5;
  localparam int SYN  = 2;
  localparam int L_ON  = SYN + 1;
  localparam int L_OFF = SYN + DLY;

  logic clk = 1'b0;
  logic rst_n, tick, sup, sns, man_n, wd;
  logic a_c, b_c, da_c, db_c, a_d, b_d, da_d, db_d;
  logic [1:0] cz_c, cz_d;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  supv_reset_seq #(.DUAL_MODE(1'b0), .DELAY_TICKS(DLY), .SYNC_STAGES(SYN), .OD_STYLE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick), .supply_ok_in(sup), .sense_ok_in(sns),
    .man_rst_in_n(man_n), .wdog_expire(wd), .rst_a_n(a_c), .rst_b_n(b_c),
    .drv_a_en(da_c), .drv_b_en(db_c), .last_cause(cz_c));

  supv_reset_seq #(.DUAL_MODE(1'b1), .DELAY_TICKS(DLY), .SYNC_STAGES(SYN), .OD_STYLE(1'b1)) dut2_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick), .supply_ok_in(sup), .sense_ok_in(sns),
    .man_rst_in_n(man_n), .wdog_expire(wd), .rst_a_n(a_d), .rst_b_n(b_d),
    .drv_a_en(da_d), .drv_b_en(db_d), .last_cause(cz_d));

  task automatic check(input string req, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Steps until rst_a_n of the combined instance reaches val; -1 if never.
  task automatic lat_a(input logic val, input int maxn, output int n);
    bit found = 0;
    n = 0;
    while (!found && n < maxn) begin
      step(1);
      n++;
      if (a_c == val) found = 1;
    end
    if (!found) n = -1;
  endtask

  task automatic pulse_wd();
    wd = 1'b1;
    step(1);
    wd = 1'b0;
  endtask

  initial begin
    int n;
    rst_n = 0; tick = 1; sup = 0; sns = 0; man_n = 1; wd = 0;
    step(3);
    check("R1 comb out low", a_c, 0);
    check("R1 comb out b low", b_c, 0);
    check("R1 dual out a low", a_d, 0);
    check("R1 dual out b low", b_d, 0);
    check("R1 cause supply", cz_c, 0);
    check("R11 push-pull enable", da_c, 1);
    check("R11 open-drain enable asserted", da_d, 1);

    rst_n = 1; sup = 1; sns = 1;
    lat_a(1'b1, 40, n);
    check("R3 power-up release latency", n, L_OFF);
    check("R3 dual a released", a_d, 1);
    check("R3 dual b released", b_d, 1);
    check("R11 open-drain enable released", da_d, 0);
    check("R11 push-pull enable held", db_c, 1);

    // Supply drop
    sup = 0;
    lat_a(1'b0, 20, n);
    check("R2 supply assert latency", n, L_ON);
    check("R2 dual a follows supply", a_d, 0);
    check("R7 dual b ignores supply", b_d, 1);
    check("R10 cause supply", cz_c, 0);
    sup = 1;
    lat_a(1'b1, 40, n);
    check("R3 release after supply", n, L_OFF);

    // Sweep of drop position through the delay window
    for (int k = 1; k <= L_OFF + 2; k++) begin
      sup = 0;
      step(4);
      sup = 1;
      step(k);
      check($sformatf("R3 released after %0d steps", k), a_c, (k >= L_OFF) ? 1 : 0);
      sup = 0;
      step(4);
      check($sformatf("R4 reasserted k=%0d", k), a_c, 0);
      sup = 1;
      lat_a(1'b1, 40, n);
      check($sformatf("R4 full restart k=%0d", k), n, L_OFF);
    end

    // Manual reset
    man_n = 0;
    lat_a(1'b0, 20, n);
    check("R5 manual assert latency", n, L_ON);
    check("R5 dual a low", a_d, 0);
    check("R5 dual b low", b_d, 0);
    check("R10 cause manual", cz_c, 2);
    step(12);
    check("R5 held while pressed", a_c, 0);
    man_n = 1;
    lat_a(1'b1, 40, n);
    check("R5 release latency", n, L_OFF);
    check("R5 dual b released", b_d, 1);
    check("R10 cause kept after release", cz_d, 2);

    // Sense flag
    sns = 0;
    lat_a(1'b0, 20, n);
    check("R6 sense assert latency", n, L_ON);
    check("R6 single reset mirrors", b_c, 0);
    check("R7 dual b follows sense", b_d, 0);
    check("R7 dual a ignores sense", a_d, 1);
    check("R10 cause sense", cz_c, 1);
    sns = 1;
    lat_a(1'b1, 40, n);
    check("R6 sense release latency", n, L_OFF);
    check("R7 dual b release", b_d, 1);

    // Watchdog pulse: low for exactly DLY samples
    pulse_wd();
    check("R8 wdog asserted next edge", a_c, 0);
    check("R6 wdog on single reset b", b_c, 0);
    check("R7 dual b ignores wdog", b_d, 1);
    check("R10 cause wdog", cz_c, 3);
    n = 1;
    while (a_c == 1'b0 && n < 50) begin
      step(1);
      if (a_c == 1'b0) n++;
    end
    check("R8 wdog low duration", n, DLY);

    // Watchdog retrigger sweep
    for (int j = 1; j < DLY; j++) begin
      pulse_wd();
      step(j - 1);
      pulse_wd();
      lat_a(1'b1, 40, n);
      check($sformatf("R8 retrigger offset %0d", j), n + 1, DLY + 1);
    end

    // No ticks: no release
    sup = 0;
    step(4);
    tick = 0;
    sup = 1;
    step(30);
    check("R9 held without ticks", a_c, 0);
    check("R9 dual held without ticks", a_d, 0);
    tick = 1;
    lat_a(1'b1, 40, n);
    check("R9 release after ticks resume", n, DLY);

    // Priority on simultaneous causes
    sup = 0; man_n = 0;
    lat_a(1'b0, 20, n);
    check("R10 supply beats manual", cz_c, 0);
    sup = 1; man_n = 1;
    lat_a(1'b1, 40, n);
    man_n = 0; sns = 0;
    lat_a(1'b0, 20, n);
    check("R10 manual beats sense", cz_c, 2);
    man_n = 1; sns = 1;
    lat_a(1'b1, 40, n);
    check("R4 release after pair", n, L_OFF);

    // Power-on reset mid operation
    rst_n = 0;
    step(1);
    check("R1 reapplied reset asserts", a_c, 0);
    check("R1 reapplied reset dual b", b_d, 0);
    check("R1 cause after reset", cz_d, 0);
    rst_n = 1;
    lat_a(1'b1, 40, n);
    check("R1 release after reset", n, L_OFF);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule